// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains the chain of extended capability headers that sits in the upper part of a 4 KB configuration space. Each header is one dword. The low 16 bits hold the capability identifier, bits 19:16 hold a 4-bit version, and bits 31:20 hold the byte offset of the following header. An offset of zero there ends the chain. The chain always begins at byte 256. The block reads and writes the configuration memory through a single-port synchronous RAM interface with one cycle of read latency, and the memory itself lives outside the block.

A lookup request walks the chain one header at a time. It reports where the requested identifier sits and which header came before it. A search for identifier 0 never matches any header, so that search reports the last header of the chain. An insert request first validates its offset and size. When the offset is 256, the new header keeps the forward link that was already stored there. For any other offset, the block walks to the tail, rewrites the tail's link to point at the new offset, and writes the new header with a zero link. In both cases the block then sweeps the inserted byte range through a mask-write port, which clears the write-enable and write-one-to-clear masks and sets the compare mask. A corrupt chain (a bad link or a loop) ends the operation with an error flag and does not hang the engine.

Top module: `xcap_chain`

## Requirements
- R1: A header dword carries the identifier in bits 15:0, the version in bits 19:16 and the next-header byte offset in bits 31:20. The chain starts at byte 256, which is dword address 64.
- R2: A lookup on an empty chain (the dword at byte 256 reads zero) completes with `res_off` = 0 and `res_prev` = 0 and no flag set.
- R3: A lookup whose identifier matches a header returns that header's byte offset in `res_off` and the offset of the header visited just before it in `res_prev`, which is 0 for a match at the head.
- R4: A lookup that reaches a zero link without a match returns `res_off` = 0 and returns the last visited offset (the tail) in `res_prev`.
- R5: Identifier 0 never matches any header. A lookup for it always returns `res_off` = 0 and the tail in `res_prev`.
- R6: If a link that is about to be followed is below 256 or above 4088, the operation ends with `err_bound` set, both results at 0, and no write.
- R7: `err_align` flags a link that is not a multiple of 4 during a walk (checked ahead of the bound check). It also flags an insert offset that is not a multiple of 4, and that insert is rejected as well.
- R8: When a walk has read 1024 headers (`MAX_STEPS`) without reaching a match or a zero link, it ends with `err_steps` set and both results at 0.
- R9: An insert at byte 256 writes the header {old link at 256, version, id} and returns `res_off` = 256 and `res_prev` = 0.
- R10: An insert at any other offset rewrites only the tail header's link field to the new offset, writes the new header with a zero link, and returns `res_off` = the new offset and `res_prev` = the tail.
- R11: An insert is rejected with `rejected` set, both results at 0 and no memory or mask write in any of these cases: the offset is below 256, the size is below 8, the offset plus the size exceeds 4096, or the offset is not 256 and the chain is empty.
- R12: After a successful insert, every byte in [offset, offset+size) receives one mask write through `msk_we`/`msk_addr`/`msk_be`, one dword per cycle, with `msk_be` bit i selecting byte i of the dword. No byte outside that range is written.
- R13: Requests are sampled only while `busy` is low, and a lookup takes priority over an insert. A request raised while `busy` is high is ignored. `done` is a one-cycle pulse with `busy` low, and the results and flags hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| find_req | input | 1 | Start a lookup |
| find_id | input | 16 | Identifier to look up |
| app_req | input | 1 | Start an insert |
| app_id | input | 16 | Identifier of the new header |
| app_ver | input | 4 | Version of the new header |
| app_off | input | 12 | Byte offset of the new header |
| app_size | input | 13 | Byte size of the new capability |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_off | output | 12 | Matched or inserted offset |
| res_prev | output | 12 | Offset of the preceding header |
| err_bound | output | 1 | Link outside the legal range |
| err_align | output | 1 | Misaligned link or offset |
| err_steps | output | 1 | Walk step limit reached |
| rejected | output | 1 | Insert request refused |
| cfg_en | output | 1 | Configuration RAM enable |
| cfg_we | output | 1 | Configuration RAM write enable |
| cfg_addr | output | 10 | Configuration RAM dword address |
| cfg_wdata | output | 32 | Configuration RAM write data |
| cfg_rdata | input | 32 | Configuration RAM read data, one cycle after a read |
| msk_we | output | 1 | Mask RAM sweep write |
| msk_addr | output | 10 | Mask RAM dword address |
| msk_be | output | 4 | Mask RAM byte strobes |

## Verification
The lookup is tried on an empty chain, on a single head, and on a three- and four-link chain. On that chain it searches for the head, a middle link and the tail, which separates a correct previous-offset report from an off-by-one. It also searches for an absent identifier and for identifier 0, which shows whether the reserved identifier can ever match. Inserts go at the head (on an empty chain and again on a populated one, to show the old link survives), with a size that is not a multiple of four (to exercise partial byte strobes), and at the last legal offset. The chain is then deliberately corrupted with a low link, a misaligned link and a loop back to the head, which tells the three abort causes apart and shows that a corrupt insert writes nothing.

// File: rtl/xcap_pkg.sv
package xcap_pkg;
    localparam int CFG_BYTES = 4096;
    localparam int OFF_W     = $clog2(CFG_BYTES);
    localparam int DADDR_W   = OFF_W - 2;
    localparam int SIZE_W    = OFF_W + 1;
    localparam int ID_W      = 16;
    localparam int VER_W     = 4;
    localparam int WORD_W    = ID_W + VER_W + OFF_W;

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_CHK, S_PATCH, S_HDR, S_MASK
    } state_e;

    typedef enum logic [1:0] {
        OP_FIND, OP_TAIL, OP_HEAD
    } op_e;

    typedef enum logic [1:0] {
        H_STEP, H_FOUND, H_END, H_EMPTY
    } hkind_e;
endpackage

// File: rtl/xcap_hdr_eval.sv
module xcap_hdr_eval
    import xcap_pkg::*;
#(
    parameter int HEAD_OFF = 256
) (
    input  logic [WORD_W-1:0] hdr,
    input  logic [OFF_W-1:0]  cur,
    input  logic [ID_W-1:0]   search_id,
    output hkind_e            kind,
    output logic [OFF_W-1:0]  nxt,
    output logic              nxt_mis,
    output logic              nxt_oob
);
    localparam logic [OFF_W-1:0] LO = OFF_W'(HEAD_OFF);
    localparam logic [OFF_W-1:0] HI = OFF_W'(CFG_BYTES - 8);

    assign nxt     = hdr[WORD_W-1 -: OFF_W];
    assign nxt_mis = nxt[1:0] != 2'b00;
    assign nxt_oob = (nxt < LO) || (nxt > HI);

    always_comb begin
        if (cur == LO && hdr == '0)
            kind = H_EMPTY;
        else if (search_id != '0 && hdr[ID_W-1:0] == search_id)
            kind = H_FOUND;
        else if (nxt == '0)
            kind = H_END;
        else
            kind = H_STEP;
    end
endmodule

// File: rtl/xcap_strobe.sv
module xcap_strobe
    import xcap_pkg::*;
(
    input  logic [DADDR_W-1:0] dw_addr,
    input  logic [SIZE_W-1:0]  end_byte,
    output logic [3:0]         be,
    output logic               last
);
    logic [SIZE_W-1:0] base;
    assign base = SIZE_W'({dw_addr, 2'b00});

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign be[i] = (base + SIZE_W'(i)) < end_byte;
    end

    assign last = (base + SIZE_W'(4)) >= end_byte;
endmodule

// File: rtl/xcap_chain.sv
module xcap_chain
    import xcap_pkg::*;
#(
    parameter int HEAD_OFF  = 256,
    parameter int MAX_STEPS = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                find_req,
    input  logic [ID_W-1:0]     find_id,
    input  logic                app_req,
    input  logic [ID_W-1:0]     app_id,
    input  logic [VER_W-1:0]    app_ver,
    input  logic [OFF_W-1:0]    app_off,
    input  logic [SIZE_W-1:0]   app_size,
    output logic                busy,
    output logic                done,
    output logic [OFF_W-1:0]    res_off,
    output logic [OFF_W-1:0]    res_prev,
    output logic                err_bound,
    output logic                err_align,
    output logic                err_steps,
    output logic                rejected,
    output logic                cfg_en,
    output logic                cfg_we,
    output logic [DADDR_W-1:0]  cfg_addr,
    output logic [WORD_W-1:0]   cfg_wdata,
    input  logic [WORD_W-1:0]   cfg_rdata,
    output logic                msk_we,
    output logic [DADDR_W-1:0]  msk_addr,
    output logic [3:0]          msk_be
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [OFF_W-1:0] HEAD = OFF_W'(HEAD_OFF);
    localparam logic [OFF_W+1:0] SPACE = (OFF_W + 2)'(CFG_BYTES);

    typedef struct packed {
        state_e              st;
        op_e                 op;
        logic [ID_W-1:0]     id;
        logic [VER_W-1:0]    ver;
        logic [OFF_W-1:0]    aoff;
        logic [SIZE_W-1:0]   aend;
        logic [OFF_W-1:0]    cur;
        logic [OFF_W-1:0]    prev;
        logic [WORD_W-1:0]   hdr;
        logic [STEP_W-1:0]   steps;
        logic [DADDR_W-1:0]  maddr;
        logic                done;
        logic [OFF_W-1:0]    roff;
        logic [OFF_W-1:0]    rprev;
        logic                ebnd;
        logic                ealn;
        logic                estp;
        logic                rej;
    } ctx_t;

    ctx_t q, d;

    // header classification of the dword just read
    hkind_e            kind;
    logic [OFF_W-1:0]  nxt;
    logic              nxt_mis, nxt_oob;
    logic [ID_W-1:0]   search_id;

    assign search_id = (q.op == OP_FIND) ? q.id : '0;

    xcap_hdr_eval #(.HEAD_OFF(HEAD_OFF)) u_eval (
        .hdr       (cfg_rdata),
        .cur       (q.cur),
        .search_id (search_id),
        .kind      (kind),
        .nxt       (nxt),
        .nxt_mis   (nxt_mis),
        .nxt_oob   (nxt_oob)
    );

    // byte strobes for the mask sweep
    logic [3:0] sweep_be;
    logic       sweep_last;

    xcap_strobe u_strobe (
        .dw_addr  (q.maddr),
        .end_byte (q.aend),
        .be       (sweep_be),
        .last     (sweep_last)
    );

    // insert validation, decided in the accept cycle
    logic a_mis, a_bad;
    assign a_mis = app_off[1:0] != 2'b00;
    assign a_bad = a_mis || (app_off < HEAD) || (app_size < SIZE_W'(8)) ||
                   (({2'b00, app_off} + {1'b0, app_size}) > SPACE);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (find_req || app_req) begin
                    d.roff  = '0;
                    d.rprev = '0;
                    d.ebnd  = 1'b0;
                    d.ealn  = 1'b0;
                    d.estp  = 1'b0;
                    d.rej   = 1'b0;
                    d.cur   = HEAD;
                    d.prev  = '0;
                    d.steps = '0;
                end
                if (find_req) begin
                    d.op = OP_FIND;
                    d.id = find_id;
                    d.st = S_RD;
                end else if (app_req) begin
                    d.id   = app_id;
                    d.ver  = app_ver;
                    d.aoff = app_off;
                    d.aend = SIZE_W'(app_off) + app_size;
                    d.op   = (app_off == HEAD) ? OP_HEAD : OP_TAIL;
                    if (a_bad) begin
                        d.rej  = 1'b1;
                        d.ealn = a_mis;
                        d.done = 1'b1;
                    end else begin
                        d.st = S_RD;
                    end
                end
            end
            S_RD: d.st = S_CHK;
            S_CHK: begin
                d.hdr = cfg_rdata;
                d.st  = S_IDLE;
                if (q.op == OP_HEAD) begin
                    d.st = S_HDR;
                end else begin
                    unique case (kind)
                        H_EMPTY: begin
                            d.rej  = (q.op != OP_FIND);
                            d.done = 1'b1;
                        end
                        H_FOUND: begin
                            d.roff  = q.cur;
                            d.rprev = q.prev;
                            d.done  = 1'b1;
                        end
                        H_END: begin
                            if (q.op == OP_FIND) begin
                                d.rprev = q.cur;
                                d.done  = 1'b1;
                            end else begin
                                d.st = S_PATCH;
                            end
                        end
                        default: begin
                            if (int'(q.steps) + 1 >= MAX_STEPS) begin
                                d.estp = 1'b1;
                                d.done = 1'b1;
                            end else if (nxt_mis) begin
                                d.ealn = 1'b1;
                                d.done = 1'b1;
                            end else if (nxt_oob) begin
                                d.ebnd = 1'b1;
                                d.done = 1'b1;
                            end else begin
                                d.prev  = q.cur;
                                d.cur   = nxt;
                                d.steps = q.steps + 1'b1;
                                d.st    = S_RD;
                            end
                        end
                    endcase
                end
            end
            S_PATCH: d.st = S_HDR;
            S_HDR: begin
                d.maddr = q.aoff[OFF_W-1:2];
                d.st    = S_MASK;
            end
            S_MASK: begin
                d.maddr = q.maddr + 1'b1;
                if (sweep_last) begin
                    d.roff  = q.aoff;
                    d.rprev = (q.op == OP_HEAD) ? '0 : q.cur;
                    d.done  = 1'b1;
                    d.st    = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // memory interface driven from registered state
    assign cfg_en    = (q.st == S_RD) || (q.st == S_PATCH) || (q.st == S_HDR);
    assign cfg_we    = (q.st == S_PATCH) || (q.st == S_HDR);
    assign cfg_addr  = (q.st == S_HDR) ? q.aoff[OFF_W-1:2] : q.cur[OFF_W-1:2];
    assign cfg_wdata = (q.st == S_PATCH)
                     ? {q.aoff, q.hdr[ID_W+VER_W-1:0]}
                     : {((q.op == OP_HEAD) ? q.hdr[WORD_W-1 -: OFF_W] : {OFF_W{1'b0}}),
                        q.ver, q.id};

    assign msk_we   = (q.st == S_MASK);
    assign msk_addr = q.maddr;
    assign msk_be   = (q.st == S_MASK) ? sweep_be : 4'b0000;

    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign res_off   = q.roff;
    assign res_prev  = q.rprev;
    assign err_bound = q.ebnd;
    assign err_align = q.ealn;
    assign err_steps = q.estp;
    assign rejected  = q.rej;
endmodule

// File: rtl/xcap_chain_chk.sv
module xcap_chain_chk #(
    parameter int HEAD_OFF = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        find_req,
    input logic        app_req,
    input logic [12:0] app_size,
    input logic        rejected,
    input logic        err_bound,
    input logic        err_align,
    input logic        err_steps,
    input logic        cfg_en,
    input logic        cfg_we,
    input logic [9:0]  cfg_addr,
    input logic        msk_we,
    input logic [9:0]  msk_addr,
    input logic [3:0]  msk_be
);
    localparam logic [9:0] HEAD_DW = 10'(HEAD_OFF / 4);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cfg_en && !msk_we));

    // R11
    write_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (cfg_addr >= HEAD_DW));

    // R12
    sweep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |-> ((msk_addr >= HEAD_DW) && (msk_be != 4'b0000)));

    // R11
    small_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && app_req && !find_req && app_size < 13'd8) |=> (done && rejected));

    // R6
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({err_bound, err_align, err_steps}));
endmodule

bind xcap_chain xcap_chain_chk #(.HEAD_OFF(HEAD_OFF)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .find_req  (find_req),
    .app_req   (app_req),
    .app_size  (app_size),
    .rejected  (rejected),
    .err_bound (err_bound),
    .err_align (err_align),
    .err_steps (err_steps),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .msk_we    (msk_we),
    .msk_addr  (msk_addr),
    .msk_be    (msk_be)
);

// File: tb/test_xcap_chain.sv
module test_xcap_chain;
    localparam int MAXS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        find_req = 1'b0;
    logic [15:0] find_id = '0;
    logic        app_req = 1'b0;
    logic [15:0] app_id = '0;
    logic [3:0]  app_ver = '0;
    logic [11:0] app_off = '0;
    logic [12:0] app_size = '0;
    logic        busy, done, err_bound, err_align, err_steps, rejected;
    logic [11:0] res_off, res_prev;
    logic        cfg_en, cfg_we, msk_we;
    logic [9:0]  cfg_addr, msk_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [3:0]  msk_be;

    always #4 clk = ~clk;

    xcap_chain i_xcap_chain (.*);

    logic [31:0] mem  [0:1023];
    logic [31:0] rmem [0:1023];
    logic [7:0]  wm [0:4095], wc [0:4095], cm [0:4095];
    logic [7:0]  rwm[0:4095], rwc[0:4095], rcm[0:4095];

    always_ff @(posedge clk) begin
        if (cfg_en) begin
            if (cfg_we) mem[cfg_addr] <= cfg_wdata;
            cfg_rdata <= mem[cfg_addr];
        end
        if (msk_we) begin
            for (int i = 0; i < 4; i++) begin
                if (msk_be[i]) begin
                    wm[{msk_addr, 2'(i)}] <= 8'h00;
                    wc[{msk_addr, 2'(i)}] <= 8'h00;
                    cm[{msk_addr, 2'(i)}] <= 8'hFF;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int e_off, e_prev;
    bit e_bnd, e_aln, e_stp, e_rej;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // every-clock protocol comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check("R13", "done while busy", int'(done && busy), 0);
            check("R13", "memory access while idle", int'(!busy && (cfg_en || msk_we)), 0);
        end
    end

    task automatic clear_all();
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; rmem[i] = '0; end
        for (int i = 0; i < 4096; i++) begin
            wm[i] = 8'hA5; wc[i] = 8'h5A; cm[i] = 8'h00;
            rwm[i] = 8'hA5; rwc[i] = 8'h5A; rcm[i] = 8'h00;
        end
    endtask

    task automatic poke(input int byte_off, input logic [31:0] v);
        mem[byte_off/4] = v;
        rmem[byte_off/4] = v;
    endtask

    // behavioural chain walk over the reference copy
    task automatic ref_walk(input logic [15:0] sid, output bit empty, output bit errd,
                            output bit ended, output int o_off, output int o_prev);
        int cur = 256;
        int prv = 0;
        int n = 0;
        int nx;
        logic [31:0] h;
        empty = 0; errd = 0; ended = 0; o_off = 0; o_prev = 0;
        if (rmem[64] == 0) begin empty = 1; return; end
        forever begin
            h = rmem[cur/4];
            n++;
            if (sid != 0 && h[15:0] == sid) begin o_off = cur; o_prev = prv; return; end
            nx = int'(h[31:20]);
            if (nx == 0) begin ended = 1; o_prev = cur; return; end
            if (n >= MAXS) begin e_stp = 1; errd = 1; return; end
            if (nx % 4 != 0) begin e_aln = 1; errd = 1; return; end
            if (nx < 256 || nx > 4088) begin e_bnd = 1; errd = 1; return; end
            prv = cur;
            cur = nx;
        end
    endtask

    task automatic ref_fill(input int off, input int size);
        for (int b = off; b < off + size; b++) begin
            rwm[b] = 8'h00; rwc[b] = 8'h00; rcm[b] = 8'hFF;
        end
    endtask

    task automatic run_op(input string tag, input bit is_app, input logic [15:0] id,
                          input logic [3:0] ver, input int off, input int size, input bit poke_busy);
        bit empty, errd, ended;
        int o_off, o_prev, waited, bad;
        logic [31:0] h;
        e_off = 0; e_prev = 0; e_bnd = 0; e_aln = 0; e_stp = 0; e_rej = 0;
        if (!is_app) begin
            ref_walk(id, empty, errd, ended, o_off, o_prev);
            e_off = o_off; e_prev = o_prev;
        end else if (off < 256 || size < 8 || off + size > 4096 || off % 4 != 0) begin
            e_rej = 1;
            e_aln = (off % 4 != 0);
        end else if (off == 256) begin
            h = rmem[64];
            rmem[64] = {h[31:20], ver, id};
            e_off = 256;
            ref_fill(off, size);
        end else begin
            ref_walk(16'h0000, empty, errd, ended, o_off, o_prev);
            if (empty) e_rej = 1;
            else if (!errd) begin
                rmem[o_prev/4][31:20] = 12'(off);
                rmem[off/4] = {12'h000, ver, id};
                e_off = off;
                e_prev = o_prev;
                ref_fill(off, size);
            end
        end
        @(negedge clk);
        find_req = !is_app; find_id = id;
        app_req = is_app; app_id = id; app_ver = ver;
        app_off = 12'(off); app_size = 13'(size);
        @(negedge clk);
        find_req = 1'b0; app_req = 1'b0;
        if (poke_busy && !done) begin
            @(negedge clk);
            find_req = 1'b1; find_id = 16'h0001;
            app_req = 1'b1; app_off = 12'h080; app_size = 13'd4;
            @(negedge clk);
            find_req = 1'b0; app_req = 1'b0;
        end
        waited = 0;
        while (!done && waited < 5000) begin @(negedge clk); waited++; end
        check(tag, "completion", int'(done), 1);
        check(tag, "res_off", int'(res_off), e_off);
        check(tag, "res_prev", int'(res_prev), e_prev);
        check(tag, "err_bound", int'(err_bound), int'(e_bnd));
        check(tag, "err_align", int'(err_align), int'(e_aln));
        check(tag, "err_steps", int'(err_steps), int'(e_stp));
        check(tag, "rejected", int'(rejected), int'(e_rej));
        @(negedge clk);
        check("R13", "done pulse width", int'(done), 0);
        if (poke_busy) begin
            for (int k = 0; k < 6; k++) begin
                check("R13", "request while busy ignored", int'(done || busy), 0);
                @(negedge clk);
            end
            check("R13", "results hold", int'(res_off), e_off);
        end
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== rmem[i]) bad++;
        check(tag, "config memory mismatches", bad, 0);
        bad = 0;
        for (int i = 0; i < 4096; i++)
            if (wm[i] !== rwm[i] || wc[i] !== rwc[i] || cm[i] !== rcm[i]) bad++;
        check(tag, "mask byte mismatches", bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13", "reset busy", int'(busy), 0);
        check("R13", "reset done", int'(done), 0);
        check("R13", "reset cfg_en", int'(cfg_en), 0);
        check("R13", "reset res_off", int'(res_off), 0);

        run_op("R2",  0, 16'h0042, 4'h0, 0, 0, 0);
        run_op("R9",  1, 16'h0001, 4'h1, 256, 48, 0);
        run_op("R3",  0, 16'h0001, 4'h0, 0, 0, 0);
        run_op("R10", 1, 16'h000B, 4'h2, 'h140, 'h2A, 0);
        run_op("R12", 1, 16'h0010, 4'h1, 'h200, 8, 0);
        run_op("R3",  0, 16'h000B, 4'h0, 0, 0, 0);
        run_op("R3",  0, 16'h0010, 4'h0, 0, 0, 0);
        run_op("R4",  0, 16'h0077, 4'h0, 0, 0, 0);
        run_op("R5",  0, 16'h0000, 4'h0, 0, 0, 0);
        run_op("R9",  1, 16'h0003, 4'h1, 256, 16, 0);
        run_op("R1",  0, 16'h000B, 4'h0, 0, 0, 1);
        run_op("R11", 1, 16'h0055, 4'h1, 'h080, 16, 0);
        run_op("R11", 1, 16'h0055, 4'h1, 'h300, 4, 0);
        run_op("R11", 1, 16'h0055, 4'h1, 'hFF0, 'h20, 0);
        run_op("R7",  1, 16'h0055, 4'h1, 'h302, 16, 0);
        run_op("R10", 1, 16'h0020, 4'h1, 'hFF8, 8, 0);

        poke('hFF8, {12'h0F0, 4'h1, 16'h0020});
        run_op("R6",  0, 16'h0099, 4'h0, 0, 0, 0);
        run_op("R6",  1, 16'h0066, 4'h1, 'h300, 16, 0);
        poke('hFF8, {12'h145, 4'h1, 16'h0020});
        run_op("R7",  0, 16'h0099, 4'h0, 0, 0, 0);
        poke('hFF8, {12'h100, 4'h1, 16'h0020});
        run_op("R3",  0, 16'h0020, 4'h0, 0, 0, 0);
        run_op("R8",  0, 16'h0099, 4'h0, 0, 0, 0);

        clear_all();
        run_op("R11", 1, 16'h0044, 4'h1, 'h180, 16, 0);
        run_op("R2",  0, 16'h0044, 4'h0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule